// File: doc/BRIEF.md
# PHY Management Register File

This block holds the management registers of an Ethernet PHY behind a simple parallel access port: a 5-bit register address, 16-bit write data with a write strobe, a read strobe and 16-bit read data. Every register bit follows one of five access kinds. Read/write bits hold what software writes. Read-only bits show live status or loaded data. Latch-high bits catch an event and keep it until their register is read. Self-clearing bits pulse once after being written. Permanent bits always return a constant.

Two mechanisms span the whole bank. A software reset, started from the top bit of the control register, holds every register at its default for a parameterised number of cycles. During that window the hardware strap inputs are sampled again, and the reset bit reads back as 1 until the window ends. A page-select register at the top address switches decoding between the base map and a small extended map. Status arrives as plain level and single-cycle event inputs. The serial management framing and the negotiation engine sit outside this block.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After power-up reset, control (00h) reads 2000h·s0 | 1000h·s1 | 0100h·s2 for straps s[2:0]. Advertisement (04h) reads ADV_DEF, expansion (06h) reads 0004h, next-page (07h) reads 0000h and page select (1Fh) reads 0000h. anRestart and swResetBusy are low.
- R2: The following read/write fields read back what was written, and nothing else: control bits 14 (loopback), 13 (speed), 12 (negotiation enable) and 8 (duplex); advertisement bits 15:5; next-page bits 15 and 10:0; the extended configuration register (extended 00h, default EXT_DEF).
- R3: Read-only fields ignore writes. Status bit 2 follows linkUp and bit 5 follows anDone. Partner register 05h takes partnerWord in the cycle after partnerLoad and otherwise keeps its value.
- R4: Status bit 1 (jabberEvt), status bit 4 (remoteFaultEvt) and expansion bit 1 (pageRxEvt) set in the cycle after their event. They stay set until a read of their register, which returns 1 and clears them. An event in the same cycle as that read is not lost.
- R5: Writing 1 to control bit 9 makes that bit and the anRestart output high for exactly one cycle.
- R6: Permanent bits never change: ID registers 02h/03h (ID_HI, ID_LO), status bits 15:11 (CAP) and bit 0 (=1), advertisement bits 4:0 (00001b), and expansion bit 2 (=1).
- R7: Writing 1 to control bit 15 on the base page raises swResetBusy for exactly RST_CYC cycles. During that time control bit 15 reads 1.
- R8: At the end of a software reset, every register holds its power-up default. This clears the latch-high bits and page select. Strap-derived control bits and the strap readback (extended 01h, bits 2:0) show the straps present during the reset.
- R9: All writes are ignored while swResetBusy is high, including writes to page select.
- R10: Page select (1Fh, both maps) stores write bit 0, with 1 for the extended map and 0 for the base map. Extended 00h and 01h do not alias base registers.
- R11: Next-page bit 11 (toggle) is loaded from advertisement bit 11 when control bit 9 is written to 1 and at any reset (from ADV_DEF bit 11). It inverts on each npSentEvt and ignores writes.
- R12: Base addresses 08h–1Eh and any extended address other than 00h, 01h and 1Fh read 0000h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| addr | input | 5 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe (clears latch-high bits of the addressed register) |
| rdData | output | 16 | Read data for addr, combinational |
| strapIn | input | 3 | Hardware straps: speed, negotiation enable, duplex |
| linkUp | input | 1 | Link level status |
| anDone | input | 1 | Negotiation complete level |
| jabberEvt | input | 1 | Jabber event pulse |
| remoteFaultEvt | input | 1 | Remote fault event pulse |
| pageRxEvt | input | 1 | Page received event pulse |
| npSentEvt | input | 1 | Next page sent pulse |
| partnerLoad | input | 1 | Load strobe for partner ability |
| partnerWord | input | 16 | Partner ability word |
| anRestart | output | 1 | One-cycle negotiation restart request |
| swResetBusy | output | 1 | Software reset in progress |

## Verification
The hardest state to reach is the inside of the software-reset window. There, the bench must see the defaults driven from straps that have changed since power-up, and must show that writes to both a data register and the page select are dropped. The bench changes the straps and sets a latch-high bit before it starts the reset. It then reads control and issues writes while swResetBusy is still high, and counts the busy cycles at the port. It also places a latch event in the same cycle as the clearing read, so that both priority and loss can be seen.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam logic [4:0] ADDR_CTRL = 5'h00;
  localparam logic [4:0] ADDR_STAT = 5'h01;
  localparam logic [4:0] ADDR_ID1  = 5'h02;
  localparam logic [4:0] ADDR_ID2  = 5'h03;
  localparam logic [4:0] ADDR_ADV  = 5'h04;
  localparam logic [4:0] ADDR_PART = 5'h05;
  localparam logic [4:0] ADDR_EXPN = 5'h06;
  localparam logic [4:0] ADDR_NPTX = 5'h07;
  localparam logic [4:0] ADDR_PAGE = 5'h1F;
  localparam logic [4:0] ADDR_XCFG = 5'h00;
  localparam logic [4:0] ADDR_XSTR = 5'h01;

  localparam int STRAP_W = 3;
  localparam int LH_N    = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;      // load defaults (power-up settle or soft reset)
    logic rstBusy;   // soft reset window
    logic extPage;   // extended map selected
    logic wrCtrl;
    logic wrAdv;
    logic wrNptx;
    logic wrXcfg;
    logic rdStat;
    logic rdExpn;
  } regStrobe_t;

endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int RST_CYC = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       rstReqBit,
  input  logic       pageBit,
  output regStrobe_t stb
);

  localparam int CNT_W = $clog2(RST_CYC + 1);

  logic             initPend;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             extPage;
  logic             hold;
  logic             wrOk;
  logic             rdOk;
  logic             startRst;

  assign hold     = initPend | busy;
  assign wrOk     = wrEn & ~hold;
  assign rdOk     = rdEn & ~hold;
  assign startRst = wrOk & ~extPage & (addr == ADDR_CTRL) & rstReqBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initPend <= 1'b1;
      busy     <= 1'b0;
      cnt      <= '0;
    end else begin
      initPend <= 1'b0;
      if (startRst) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(RST_CYC - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             extPage <= 1'b0;
    else if (hold)                         extPage <= 1'b0;
    else if (wrOk && addr == ADDR_PAGE)    extPage <= pageBit;
  end

  always_comb begin
    stb         = '0;
    stb.hold    = hold;
    stb.rstBusy = busy;
    stb.extPage = extPage;
    stb.wrCtrl  = wrOk & ~extPage & (addr == ADDR_CTRL);
    stb.wrAdv   = wrOk & ~extPage & (addr == ADDR_ADV);
    stb.wrNptx  = wrOk & ~extPage & (addr == ADDR_NPTX);
    stb.wrXcfg  = wrOk &  extPage & (addr == ADDR_XCFG);
    stb.rdStat  = rdOk & ~extPage & (addr == ADDR_STAT);
    stb.rdExpn  = rdOk & ~extPage & (addr == ADDR_EXPN);
  end

endmodule

// File: rtl/phy_mgmt_lh_cell.sv
module phy_mgmt_lh_cell (
  input  logic clk,
  input  logic rstN,
  input  logic flush,
  input  logic evt,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      q <= 1'b0;
    else if (flush) q <= 1'b0;
    else if (evt)   q <= 1'b1;
    else if (clr)   q <= 1'b0;
  end

endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] ID_HI   = 16'h1A2B,
  parameter logic [15:0] ID_LO   = 16'h5C31,
  parameter logic [15:0] ADV_DEF = 16'h01E1,
  parameter logic [15:0] EXT_DEF = 16'h0040,
  parameter logic [4:0]  CAP     = 5'b01111
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [4:0]         addr,
  input  logic [15:0]        wrData,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               linkUp,
  input  logic               anDone,
  input  logic               jabberEvt,
  input  logic               remoteFaultEvt,
  input  logic               pageRxEvt,
  input  logic               npSentEvt,
  input  logic               partnerLoad,
  input  logic [15:0]        partnerWord,
  output logic [15:0]        rdData,
  output logic               anRestart
);

  localparam logic [4:0] SELECTOR = 5'b00001;

  logic               ctrlLoop, ctrlSpeed, ctrlAnEn, ctrlDuplex, ctrlRestart;
  logic [15:5]        advBits;
  logic               npNext, npToggle;
  logic [10:0]        npMsg;
  logic [15:0]        partner;
  logic [15:0]        xcfg;
  logic [STRAP_W-1:0] strapLat;

  // latch-high bits: 0 jabber, 1 remote fault, 2 page received
  logic [LH_N-1:0] lhEvt, lhClr, lhQ;
  assign lhEvt = {pageRxEvt, remoteFaultEvt, jabberEvt};
  assign lhClr = {stb.rdExpn, stb.rdStat, stb.rdStat};

  for (genvar i = 0; i < LH_N; i++) begin : g_lh
    phy_mgmt_lh_cell u_cell (
      .clk  (clk),
      .rstN (rstN),
      .flush(stb.hold),
      .evt  (lhEvt[i]),
      .clr  (lhClr[i]),
      .q    (lhQ[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlLoop    <= 1'b0;
      ctrlSpeed   <= 1'b0;
      ctrlAnEn    <= 1'b0;
      ctrlDuplex  <= 1'b0;
      ctrlRestart <= 1'b0;
      advBits     <= ADV_DEF[15:5];
      npNext      <= 1'b0;
      npToggle    <= ADV_DEF[11];
      npMsg       <= '0;
      partner     <= '0;
      xcfg        <= EXT_DEF;
      strapLat    <= '0;
    end else if (stb.hold) begin
      ctrlLoop    <= 1'b0;
      ctrlSpeed   <= strapIn[0];
      ctrlAnEn    <= strapIn[1];
      ctrlDuplex  <= strapIn[2];
      ctrlRestart <= 1'b0;
      advBits     <= ADV_DEF[15:5];
      npNext      <= 1'b0;
      npToggle    <= ADV_DEF[11];
      npMsg       <= '0;
      partner     <= '0;
      xcfg        <= EXT_DEF;
      strapLat    <= strapIn;
    end else begin
      ctrlRestart <= stb.wrCtrl & wrData[9];
      if (stb.wrCtrl) begin
        ctrlLoop   <= wrData[14];
        ctrlSpeed  <= wrData[13];
        ctrlAnEn   <= wrData[12];
        ctrlDuplex <= wrData[8];
      end
      if (stb.wrAdv) advBits <= wrData[15:5];
      if (stb.wrNptx) begin
        npNext <= wrData[15];
        npMsg  <= wrData[10:0];
      end
      if (stb.wrCtrl && wrData[9]) npToggle <= advBits[11];
      else if (npSentEvt)          npToggle <= ~npToggle;
      if (partnerLoad)  partner <= partnerWord;
      if (stb.wrXcfg)   xcfg    <= wrData;
    end
  end

  assign anRestart = ctrlRestart;

  always_comb begin
    rdData = '0;
    if (!stb.extPage) begin
      case (addr)
        ADDR_CTRL: rdData = {stb.rstBusy, ctrlLoop, ctrlSpeed, ctrlAnEn, 2'b00,
                             ctrlRestart, ctrlDuplex, 8'h00};
        ADDR_STAT: rdData = {CAP, 5'b00000, anDone, lhQ[1], 1'b0, linkUp, lhQ[0], 1'b1};
        ADDR_ID1:  rdData = ID_HI;
        ADDR_ID2:  rdData = ID_LO;
        ADDR_ADV:  rdData = {advBits, SELECTOR};
        ADDR_PART: rdData = partner;
        ADDR_EXPN: rdData = {13'h0000, 1'b1, lhQ[2], 1'b0};
        ADDR_NPTX: rdData = {npNext, 3'b000, npToggle, npMsg};
        ADDR_PAGE: rdData = {15'h0000, stb.extPage};
        default:   rdData = '0;
      endcase
    end else begin
      case (addr)
        ADDR_XCFG: rdData = xcfg;
        ADDR_XSTR: rdData = {{(16-STRAP_W){1'b0}}, strapLat};
        ADDR_PAGE: rdData = {15'h0000, stb.extPage};
        default:   rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int          RST_CYC = 250,
  parameter logic [15:0] ID_HI   = 16'h1A2B,
  parameter logic [15:0] ID_LO   = 16'h5C31,
  parameter logic [15:0] ADV_DEF = 16'h01E1,
  parameter logic [15:0] EXT_DEF = 16'h0040,
  parameter logic [4:0]  CAP     = 5'b01111
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  addr,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  output logic [15:0] rdData,
  input  logic [2:0]  strapIn,
  input  logic        linkUp,
  input  logic        anDone,
  input  logic        jabberEvt,
  input  logic        remoteFaultEvt,
  input  logic        pageRxEvt,
  input  logic        npSentEvt,
  input  logic        partnerLoad,
  input  logic [15:0] partnerWord,
  output logic        anRestart,
  output logic        swResetBusy
);

  regStrobe_t stb;
  logic       extPageSel;

  phy_mgmt_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .rstReqBit(wrData[15]),
    .pageBit  (wrData[0]),
    .stb      (stb)
  );

  phy_mgmt_dp #(
    .ID_HI(ID_HI), .ID_LO(ID_LO), .ADV_DEF(ADV_DEF), .EXT_DEF(EXT_DEF), .CAP(CAP)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .addr          (addr),
    .wrData        (wrData),
    .strapIn       (strapIn),
    .linkUp        (linkUp),
    .anDone        (anDone),
    .jabberEvt     (jabberEvt),
    .remoteFaultEvt(remoteFaultEvt),
    .pageRxEvt     (pageRxEvt),
    .npSentEvt     (npSentEvt),
    .partnerLoad   (partnerLoad),
    .partnerWord   (partnerWord),
    .rdData        (rdData),
    .anRestart     (anRestart)
  );

  assign swResetBusy = stb.rstBusy;
  assign extPageSel  = stb.extPage;

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int         RST_CYC = 250,
  parameter logic [4:0] CAP     = 5'b01111
) (
  input logic        clk,
  input logic        rstN,
  input logic [4:0]  addr,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        anRestart,
  input logic        busy,
  input logic        extPage
);

  localparam int LEN_W = $clog2(RST_CYC + 1) + 1;
  logic [LEN_W-1:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  // R7
  rst_window_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == LEN_W'(RST_CYC));

  // R7
  rst_bit_reads_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !extPage && addr == 5'h00) |-> rdData[15]);

  // R7
  rst_start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn && addr == 5'h00 && wrData[15] && !extPage));

  // R5
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    anRestart |=> !anRestart);

  // R6
  stat_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!extPage && addr == 5'h01) |-> (rdData[15:11] == CAP && rdData[0]));

  // R12
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!extPage && addr >= 5'h08 && addr <= 5'h1E) |-> rdData == 16'h0000);

  // R9
  page_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !extPage);

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.RST_CYC(RST_CYC), .CAP(CAP)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .anRestart(anRestart),
  .busy     (swResetBusy),
  .extPage  (extPageSel)
);

// File: tb/phy_mgmt_regs_test.sv
`timescale 1ns/1ps
module phy_mgmt_regs_test;

  localparam int RST_CYC = 250;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic [2:0]  strapIn = 3'b101;
  logic        linkUp = 1'b0, anDone = 1'b0;
  logic        jabberEvt = 1'b0, remoteFaultEvt = 1'b0, pageRxEvt = 1'b0, npSentEvt = 1'b0;
  logic        partnerLoad = 1'b0;
  logic [15:0] partnerWord = '0;
  logic        anRestart, swResetBusy;

  int checks = 0;
  int errors = 0;
  int busyCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  phy_mgmt_regs #(.RST_CYC(RST_CYC)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .strapIn(strapIn), .linkUp(linkUp),
    .anDone(anDone), .jabberEvt(jabberEvt), .remoteFaultEvt(remoteFaultEvt),
    .pageRxEvt(pageRxEvt), .npSentEvt(npSentEvt), .partnerLoad(partnerLoad),
    .partnerWord(partnerWord), .anRestart(anRestart), .swResetBusy(swResetBusy)
  );

  always @(negedge clk) if (swResetBusy) busyCnt++;

  // {req, isWrite, addr, data}; data is the expected value for reads
  localparam int NV = 29;
  localparam logic [25:0] VEC [NV] = '{
    {4'd1,  1'b0, 5'h00, 16'h2100},  // R1 strap defaults
    {4'd6,  1'b0, 5'h01, 16'h7801},  // R6 status constants
    {4'd6,  1'b0, 5'h02, 16'h1A2B},  // R6 ID high
    {4'd6,  1'b0, 5'h03, 16'h5C31},  // R6 ID low
    {4'd1,  1'b0, 5'h04, 16'h01E1},  // R1 advert default
    {4'd1,  1'b0, 5'h06, 16'h0004},  // R1 expansion default
    {4'd1,  1'b0, 5'h07, 16'h0000},  // R1 next page default
    {4'd2,  1'b1, 5'h04, 16'hF9FF},  // R2 write advert
    {4'd6,  1'b0, 5'h04, 16'hF9E1},  // R6 selector kept
    {4'd3,  1'b1, 5'h01, 16'hFFFF},  // R3 write status
    {4'd3,  1'b0, 5'h01, 16'h7801},  // R3 unchanged
    {4'd12, 1'b1, 5'h0A, 16'h1234},  // R12 reserved write
    {4'd12, 1'b0, 5'h0A, 16'h0000},  // R12 reads zero
    {4'd10, 1'b0, 5'h1F, 16'h0000},  // R10 base page
    {4'd10, 1'b1, 5'h1F, 16'h0001},  // R10 select extended
    {4'd10, 1'b0, 5'h1F, 16'h0001},  // R10
    {4'd10, 1'b0, 5'h00, 16'h0040},  // R10 ext cfg default
    {4'd2,  1'b1, 5'h00, 16'hABCD},  // R2 ext cfg write
    {4'd2,  1'b0, 5'h00, 16'hABCD},  // R2
    {4'd10, 1'b0, 5'h01, 16'h0005},  // R10 strap readback
    {4'd12, 1'b0, 5'h04, 16'h0000},  // R12 unmapped extended
    {4'd10, 1'b1, 5'h1F, 16'h0000},  // R10 back to base
    {4'd10, 1'b0, 5'h00, 16'h2100},  // R10 control not aliased
    {4'd2,  1'b1, 5'h00, 16'h6100},  // R2 control fields
    {4'd2,  1'b0, 5'h00, 16'h6100},  // R2
    {4'd11, 1'b1, 5'h07, 16'h8923},  // R11 toggle not writable
    {4'd11, 1'b0, 5'h07, 16'h8123},  // R11
    {4'd3,  1'b1, 5'h05, 16'hFFFF},  // R3 partner read-only
    {4'd3,  1'b0, 5'h05, 16'h0000}   // R3
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #5 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(posedge clk); #1;
    sig = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 swResetBusy", {15'h0, swResetBusy}, 16'h0);
    check("R1 anRestart", {15'h0, anRestart}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:0]);
      else begin
        rd(VEC[i][20:16], v);
        check($sformatf("R%0d vector %0d", VEC[i][25:22], i), v, VEC[i][15:0]);
      end
    end

    // R4 latch-high jabber: held, cleared by read
    pulse(jabberEvt);
    rd(5'h01, v); check("R4 jabber latched", v, 16'h7803);
    rd(5'h01, v); check("R4 jabber cleared", v, 16'h7801);

    // R4 event coinciding with clearing read survives
    @(negedge clk);
    addr = 5'h01; rdEn = 1'b1; remoteFaultEvt = 1'b1;
    #5 v = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0; remoteFaultEvt = 1'b0;
    check("R4 same-cycle read", v, 16'h7801);
    rd(5'h01, v); check("R4 fault kept", v, 16'h7811);
    rd(5'h01, v); check("R4 fault cleared", v, 16'h7801);

    // R3 level status and partner load
    linkUp = 1'b1; anDone = 1'b1;
    rd(5'h01, v); check("R3 level status", v, 16'h7825);
    partnerWord = 16'h45E1;
    pulse(partnerLoad);
    partnerWord = 16'h0000;
    rd(5'h05, v); check("R3 partner load", v, 16'h45E1);

    // R4 page received in expansion
    pulse(pageRxEvt);
    rd(5'h06, v); check("R4 page rx latched", v, 16'h0006);
    rd(5'h06, v); check("R4 page rx cleared", v, 16'h0004);

    // R5 restart self clear, R11 toggle load from advert bit 11 (=1)
    wr(5'h00, 16'h6300);
    @(negedge clk);
    check("R5 restart high", {15'h0, anRestart}, 16'h1);
    rd(5'h00, v); check("R5 restart cleared", v, 16'h6100);
    check("R5 restart output low", {15'h0, anRestart}, 16'h0);
    rd(5'h07, v); check("R11 toggle loaded", v, 16'h8923);
    pulse(npSentEvt);
    rd(5'h07, v); check("R11 toggle flips", v, 16'h8123);

    // R7 R8 R9 software reset with new straps
    pulse(jabberEvt);
    strapIn = 3'b010;
    busyCnt = 0;
    wr(5'h00, 16'h8000);
    @(negedge clk);
    check("R7 busy raised", {15'h0, swResetBusy}, 16'h1);
    rd(5'h00, v); check("R7 reset bit reads one", v, 16'h9000);
    wr(5'h04, 16'h0000);
    wr(5'h1F, 16'h0001);
    for (int k = 0; k < RST_CYC + 20 && swResetBusy; k++) @(negedge clk);
    check("R7 busy length", 16'(busyCnt), 16'(RST_CYC));
    rd(5'h00, v); check("R8 control defaults", v, 16'h1000);
    rd(5'h04, v); check("R9 advert write dropped", v, 16'h01E1);
    rd(5'h1F, v); check("R9 page write dropped", v, 16'h0000);
    rd(5'h01, v); check("R8 latch cleared", v, 16'h7825);
    rd(5'h07, v); check("R8 next page default", v, 16'h0000);
    rd(5'h05, v); check("R8 partner default", v, 16'h0000);
    wr(5'h1F, 16'h0001);
    rd(5'h01, v); check("R8 straps relatched", v, 16'h0002);
    rd(5'h00, v); check("R8 ext cfg default", v, 16'h0040);
    wr(5'h1F, 16'h0000);

    finished = 1;
    finish_run();
  end

endmodule